// File: doc/BRIEF.md
# Framed SPI frame-sync controller

This block is a 16-bit SPI shift engine in clock mode 0 (SCK idles low, data launched on the falling edge, sampled on the rising edge, most significant bit first). It can also run in a framed mode, where the select pin stops acting as a held-low chip select. In that mode it carries a frame sync pulse one SCK period wide, and each pulse frames one 16-bit word.

A single configuration word sets the role, the sync mode and the SCK divider. As master, the block drives SCK and, in framed mode, drives the sync pulse. As slave, it takes SCK and sync from outside, passes them through synchronizers, and detects the pulse. Words to send are offered on a valid/ready pair. Each received word is presented with a one-cycle valid strobe.

Top module: `fspi_frame_ctrl`

## Requirements
- R1: After reset the configuration reads 0x0030: framed mode off, master role, active-low pulse, pulse one period ahead of the data, divider 3. After reset, `sck_o`, `sync_oe` and `rx_valid` are 0 and `tx_ready` is 1.
- R2: Configuration field positions are: bit 0 framed enable, bit 1 role (1 = slave, sync is an input), bit 2 pulse polarity (1 = active-high), bit 3 pulse placement (1 = pulse coincides with the first data bit, 0 = pulse one SCK period ahead of it), bits 11:4 divider. Bits 15:12 ignore writes and read back 0.
- R3: `sync_oe` is 1 exactly when framed mode is enabled and the role is master.
- R4: As master, SCK idles low, and each SCK half period lasts divider+1 system clocks.
- R5: As master, SDO carries the accepted word MSB first. The value is stable at each rising SCK edge. A frame has 16 rising edges, or 17 when framed mode places the pulse ahead of the data.
- R6: As master in framed mode, `sync_o` is at its active level for exactly the first SCK period of the frame and at its inactive level otherwise. That first period is the first data bit when the placement bit is 1, and the period before it when the bit is 0.
- R7: The master samples SDI on each rising SCK data edge. After the 16th sample, it pulses `rx_valid` for one system clock with the received word.
- R8: The master produces no SCK edge unless `tx_valid` was asserted while `tx_ready` was 1.
- R9: As slave in framed mode, a frame begins at a rising SCK edge where sync shows its active level. With placement 1 that edge also samples the MSB; with placement 0 data sampling starts on the next rising edge. After 16 samples the word is delivered with a one-cycle `rx_valid`.
- R10: As slave, a sync pulse that arrives while a frame is in progress is ignored. The frame still completes with the correct word and one strobe.
- R11: As slave in non-framed mode, bits are taken while the select input is low. A select that goes high before 16 bits discards the partial word, and no strobe is raised.
- R12: As slave, a word accepted on `tx_valid`/`tx_ready` before the frame is presented MSB first on SDO. The next bit appears after each falling SCK edge that follows a sampled bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word |
| tx_ready | output | 1 | Transmit word can be taken |
| rx_valid | output | 1 | One-cycle received-word strobe |
| rx_data | output | 16 | Received word |
| sck_o | output | 1 | SCK driven as master |
| sck_i | input | 1 | SCK received as slave |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| sync_i | input | 1 | Sync/select pin input value |
| sync_o | output | 1 | Sync pin output value |
| sync_oe | output | 1 | Sync pin output enable |

## Verification
Two events can land on the same slave SCK edge: detection of a frame start and sampling of a data bit of a frame already running. To provoke this, the bench drives a second active sync pulse in the middle of a framed slave word. It then judges the result by exactly one strobe and an unchanged received word. In non-framed slave mode, a select release can arrive at the same moment as pending bit sampling. The bench releases select after five bits and checks that no strobe appears and that the following full frame is received intact.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
    localparam int WORD_W   = 16;
    localparam int DIV_W    = 8;
    localparam int CFG_W    = 16;
    localparam int CFG_BITS = DIV_W + 4;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int SYNC_N   = 3;

    // Field order matches the readback layout: divider above four flags.
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             coin;   // pulse on first data bit
        logic             pol_hi; // pulse active-high
        logic             dir_in; // slave role, sync is an input
        logic             fr_en;  // framed mode
    } cfg_t;
endpackage

// File: rtl/fspi_cfg.sv
module fspi_cfg
    import fspi_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = cfg_t'(wdata[CFG_BITS-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= cfg_t'({DIV_RST, 4'b0000});
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = {{(CFG_W-CFG_BITS){1'b0}}, cfg_q};

    // R1: a write strobe is the only way the stored value moves
    a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata));
endmodule

// File: rtl/fspi_sckgen.sv
module fspi_sckgen
    import fspi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tick;

    always_comb begin
        gen_d = gen_q;
        tick  = run && (gen_q.cnt == div);
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.ph  = 1'b0;
        end else if (tick) begin
            gen_d.cnt = '0;
            gen_d.ph  = ~gen_q.ph;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sck       = gen_q.ph;
    assign rise_tick = tick && !gen_q.ph;
    assign fall_tick = tick && gen_q.ph;

    // R4: clock parks low once the engine stops
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck);
endmodule

// File: rtl/fspi_core.sv
module fspi_core
    import fspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              rise_tick,
    input  logic              fall_tick,
    output logic              run,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    input  logic              sck_i,
    input  logic              sync_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sync_o
);
    localparam int MSB = WORD_W - 1;

    typedef struct packed {
        logic              busy;
        logic              loaded;
        logic              rx_v;
        logic [CNT_W-1:0]  slot;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [WORD_W-1:0] rx_word;
        logic [SYNC_N-1:0] sk;
        logic [SYNC_N-2:0] sy;
        logic [SYNC_N-2:0] sd;
    } core_t;

    core_t core_d, core_q;
    logic lead, in_data, s_rise, s_fall, s_sync, s_din, frame_hit, sync_act;
    logic [CNT_W-1:0]  last_slot, next_cnt;
    logic [WORD_W-1:0] rx_next;

    always_comb begin
        core_d      = core_q;
        core_d.rx_v = 1'b0;
        core_d.sk   = {core_q.sk[SYNC_N-2:0], sck_i};
        core_d.sy   = {core_q.sy[SYNC_N-3:0], sync_i};
        core_d.sd   = {core_q.sd[SYNC_N-3:0], sdi_i};

        lead      = cfg.fr_en && !cfg.coin;
        last_slot = CNT_W'(MSB) + CNT_W'(lead);
        in_data   = core_q.slot >= CNT_W'(lead);
        s_rise    = core_q.sk[SYNC_N-2] && !core_q.sk[SYNC_N-1];
        s_fall    = !core_q.sk[SYNC_N-2] && core_q.sk[SYNC_N-1];
        s_sync    = core_q.sy[SYNC_N-2];
        s_din     = core_q.sd[SYNC_N-2];
        frame_hit = cfg.fr_en ? (s_sync == cfg.pol_hi) : !s_sync;
        next_cnt  = core_q.slot + 1'b1;
        rx_next   = {core_q.rx_sh[MSB-1:0], cfg.dir_in ? s_din : sdi_i};
        tx_ready  = cfg.dir_in ? !(core_q.loaded || core_q.busy) : !core_q.busy;

        if (!cfg.dir_in) begin
            // master: slot 0 carries the pulse; data slots follow the lead
            if (!core_q.busy) begin
                if (tx_valid) begin
                    core_d.busy  = 1'b1;
                    core_d.slot  = '0;
                    core_d.tx_sh = tx_data;
                end
            end else begin
                if (rise_tick && in_data) begin
                    core_d.rx_sh = rx_next;
                    if (core_q.slot == last_slot) begin
                        core_d.rx_v    = 1'b1;
                        core_d.rx_word = rx_next;
                    end
                end
                if (fall_tick) begin
                    if (in_data) core_d.tx_sh = core_q.tx_sh << 1;
                    if (core_q.slot == last_slot) core_d.busy = 1'b0;
                    else                          core_d.slot = next_cnt;
                end
            end
        end else begin
            // slave: edges come from the synchronized pins
            if (tx_valid && tx_ready) begin
                core_d.tx_sh  = tx_data;
                core_d.loaded = 1'b1;
            end
            if (!cfg.fr_en && s_sync) begin
                if (core_q.busy) begin
                    core_d.busy   = 1'b0;
                    core_d.slot   = '0;
                    core_d.loaded = 1'b0;
                end
            end else if (s_rise) begin
                if (!core_q.busy) begin
                    if (frame_hit) begin
                        core_d.busy = 1'b1;
                        core_d.slot = '0;
                        if (!lead) begin
                            core_d.rx_sh = rx_next;
                            core_d.slot  = CNT_W'(1);
                        end
                    end
                end else begin
                    core_d.rx_sh = rx_next;
                    core_d.slot  = next_cnt;
                    if (next_cnt == CNT_W'(WORD_W)) begin
                        core_d.busy    = 1'b0;
                        core_d.loaded  = 1'b0;
                        core_d.rx_v    = 1'b1;
                        core_d.rx_word = rx_next;
                    end
                end
            end else if (s_fall && core_q.busy && core_q.slot != '0) begin
                core_d.tx_sh = core_q.tx_sh << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign run      = core_q.busy && !cfg.dir_in;
    assign sync_act = !cfg.dir_in && cfg.fr_en && core_q.busy && (core_q.slot == '0);
    assign sync_o   = sync_act ? cfg.pol_hi : !cfg.pol_hi;
    assign sdo_o    = core_q.tx_sh[MSB];
    assign rx_valid = core_q.rx_v;
    assign rx_data  = core_q.rx_word;

    // R7: received-word strobe lasts one clock
    a_r7_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R6: pulse ends with the first SCK period
    a_r6_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_act && fall_tick) |=> !sync_act);
    // R8: master stays idle without an offered word
    a_r8_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.dir_in && !core_q.busy && !tx_valid) |=> !core_q.busy);
    // R10: a framed slave bit count never steps back mid-frame
    a_r10_count_mono: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.dir_in && cfg.fr_en && core_q.busy)
            |=> (!core_q.busy || core_q.slot >= $past(core_q.slot)));
    // R5: bit position never passes the word length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.slot <= CNT_W'(WORD_W));
endmodule

// File: rtl/fspi_frame_ctrl.sv
module fspi_frame_ctrl
    import fspi_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [15:0]             cfg_wdata,
    output logic [15:0]             cfg_rdata,
    input  logic                    tx_valid,
    input  logic [15:0]             tx_data,
    output logic                    tx_ready,
    output logic                    rx_valid,
    output logic [15:0]             rx_data,
    output logic                    sck_o,
    input  logic                    sck_i,
    output logic                    sdo_o,
    input  logic                    sdi_i,
    input  logic                    sync_i,
    output logic                    sync_o,
    output logic                    sync_oe
);
    cfg_t cfg;
    logic run, rise_tick, fall_tick;

    fspi_cfg #(.DIV_RST(8'd3)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    fspi_sckgen u_sckgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div       (cfg.div),
        .sck       (sck_o),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    fspi_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .run       (run),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .sck_i     (sck_i),
        .sync_i    (sync_i),
        .sdi_i     (sdi_i),
        .sdo_o     (sdo_o),
        .sync_o    (sync_o)
    );

    assign sync_oe = cfg.fr_en && !cfg.dir_in;

    // R3: a slave never drives the sync pin
    a_r3_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1] |-> !sync_oe);
endmodule

// File: tb/fspi_frame_ctrl_bench.sv
`timescale 1ns/1ps
module fspi_frame_ctrl_bench;
    localparam int H = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0, tx_valid = 1'b0;
    logic [15:0] cfg_wdata = '0, tx_data = '0, cfg_rdata, rx_data;
    logic tx_ready, rx_valid, sck_o, sdo_o, sync_o, sync_oe;
    logic s_sck = 1'b0, s_sync = 1'b1, s_sdi = 1'b0, m_sdi = 1'b0, tb_slave = 1'b0;
    logic sdi_w;
    assign sdi_w = tb_slave ? s_sdi : m_sdi;

    int n_chk = 0, n_fail = 0;
    logic [15:0] cfg_m;
    bit mon_on = 0;

    // master-side observation state
    int rises = 0, slot = 0, hi_len = 0, hi_last = 0, rx_cnt = 0, mlead = 0;
    logic prev_sck = 1'b0;
    logic [15:0] mrw = '0, rx_last = '0;
    logic sdo_cap [0:31];
    logic syn_cap [0:31];

    always #2 clk = ~clk;

    fspi_frame_ctrl u_fspi_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .sck_o(sck_o), .sck_i(s_sck), .sdo_o(sdo_o), .sdi_i(sdi_w),
        .sync_i(s_sync), .sync_o(sync_o), .sync_oe(sync_oe));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference configuration model, compared every clock
    always @(posedge clk) begin
        if (!rst_n)      cfg_m <= 16'h0030;
        else if (cfg_wr) cfg_m <= cfg_wdata & 16'h0FFF;
    end
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            chk(cfg_rdata == cfg_m, "R2 readback", cfg_rdata, cfg_m);
            chk(sync_oe == (cfg_m[0] && !cfg_m[1]), "R3 sync_oe", sync_oe, cfg_m[0] && !cfg_m[1]);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
            if (sck_o && !prev_sck) begin
                sdo_cap[rises] = sdo_o; syn_cap[rises] = sync_o; rises++; hi_len = 0;
            end
            if (sck_o) hi_len++;
            if (!sck_o && prev_sck) begin
                hi_last = hi_len; slot++;
                m_sdi = (slot >= mlead && slot - mlead < 16) ? mrw[15 - (slot - mlead)] : 1'b0;
            end
            prev_sck = sck_o;
        end
    end

    function automatic logic [15:0] mk(bit fr, bit dir, bit pol, bit coin, logic [7:0] dv);
        return {4'b0000, dv, coin, pol, dir, fr};
    endfunction

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic master_frame(input logic [15:0] tw, rw, input bit fr, pol, coin, input int dv);
        int lead, rc0, errs, guard;
        lead = (fr && !coin) ? 1 : 0;
        wr_cfg(mk(fr, 1'b0, pol, coin, 8'(dv)));
        tb_slave = 1'b0; mlead = lead; mrw = rw; rises = 0; slot = 0; rc0 = rx_cnt;
        m_sdi = rw[15];
        @(negedge clk); tx_valid = 1'b1; tx_data = tw;
        @(negedge clk); tx_valid = 1'b0;
        guard = 0;
        while (!(rises == 16 + lead && !sck_o && rx_cnt != rc0) && guard < 4000) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
        chk(rises == 16 + lead, "R5 rising edge count", rises, 16 + lead);
        errs = 0;
        for (int k = 0; k < 16; k++) if (sdo_cap[k + lead] !== tw[15 - k]) errs++;
        chk(errs == 0, "R5 sdo bits", errs, 0);
        chk(hi_last == dv + 1, "R4 half period", hi_last, dv + 1);
        chk(rx_cnt == rc0 + 1 && rx_last == rw, "R7 received word", rx_last, rw);
        if (fr) begin
            errs = 0;
            for (int k = 0; k < 16 + lead; k++) if (syn_cap[k] !== (k == 0 ? pol : !pol)) errs++;
            chk(errs == 0, "R6 sync pulse placement", errs, 0);
            chk(sync_o == !pol, "R6 sync idle level", sync_o, !pol);
        end
    endtask

    task automatic slave_frame(input logic [15:0] w, tw, input bit fr, pol, coin, inj);
        int lead, rc0, errs;
        lead = (fr && !coin) ? 1 : 0;
        wr_cfg(mk(fr, 1'b1, pol, coin, 8'd3));
        tb_slave = 1'b1; rc0 = rx_cnt; errs = 0;
        s_sync = fr ? !pol : 1'b1;
        @(negedge clk); tx_valid = 1'b1; tx_data = tw;
        chk(tx_ready == 1'b1, "R12 slave ready", tx_ready, 1);
        @(negedge clk); tx_valid = 1'b0;
        if (!fr) s_sync = 1'b0;
        repeat (H) @(negedge clk);
        for (int k = 0; k < 16 + lead; k++) begin
            s_sdi = (k >= lead) ? w[15 - (k - lead)] : 1'b0;
            if (fr) s_sync = (k == 0 || (inj && k == 6)) ? pol : !pol;
            repeat (H) @(negedge clk);
            if (k >= lead && sdo_o !== tw[15 - (k - lead)]) errs++;
            s_sck = 1'b1;
            repeat (H) @(negedge clk);
            s_sck = 1'b0;
        end
        s_sync = fr ? !pol : 1'b1;
        repeat (10) @(negedge clk);
        chk(rx_cnt == rc0 + 1, inj ? "R10 one strobe despite stray sync" : "R9 one strobe", rx_cnt - rc0, 1);
        chk(rx_last == w, inj ? "R10 word intact" : "R9 slave word", rx_last, w);
        chk(errs == 0, "R12 slave sdo bits", errs, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;
        chk(cfg_rdata == 16'h0030, "R1 reset config", cfg_rdata, 16'h0030);
        chk(!sck_o && !sync_oe && !rx_valid, "R1 reset outputs", {sck_o, sync_oe, rx_valid}, 0);
        chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);

        repeat (60) @(negedge clk);
        chk(rises == 0 && !sck_o, "R8 no clock without tx_valid", rises, 0);

        wr_cfg(16'hFFFF);
        @(negedge clk);
        chk(cfg_rdata == 16'h0FFF, "R2 upper bits read zero", cfg_rdata, 16'h0FFF);

        master_frame(16'hA5C3, 16'h3C96, 1'b0, 1'b0, 1'b0, 3);
        master_frame(16'h8001, 16'hF00F, 1'b1, 1'b0, 1'b0, 2);
        master_frame(16'h1234, 16'hBEEF, 1'b1, 1'b1, 1'b1, 1);
        master_frame(16'hFFFE, 16'h0001, 1'b1, 1'b1, 1'b0, 0);
        chk(sync_oe == 1'b1, "R3 framed master drives sync", sync_oe, 1);

        slave_frame(16'hC35A, 16'h6B2D, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(sync_oe == 1'b0, "R3 slave leaves sync undriven", sync_oe, 0);
        slave_frame(16'h5AA5, 16'h9001, 1'b1, 1'b1, 1'b1, 1'b1);
        slave_frame(16'h0F1E, 16'hE1F0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R11: partial non-framed word discarded on select release
        begin
            int rc0;
            rc0 = rx_cnt;
            s_sync = 1'b0;
            repeat (H) @(negedge clk);
            for (int k = 0; k < 5; k++) begin
                s_sdi = k[0];
                repeat (H) @(negedge clk); s_sck = 1'b1;
                repeat (H) @(negedge clk); s_sck = 1'b0;
            end
            s_sync = 1'b1;
            repeat (12) @(negedge clk);
            chk(rx_cnt == rc0, "R11 no strobe after release", rx_cnt - rc0, 0);
        end
        slave_frame(16'h7E81, 16'h2468, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rx_last == 16'h7E81, "R11 next word after release", rx_last, 16'h7E81);

        mon_on = 0;
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule